// File: doc/BRIEF.md
# Look-Ahead Pipelined Single-Pole Recursive Filter

This block is a first-order recursive filter, y[n] = b1·y[n-1] + x[n], that takes one signed sample per clock and returns one filtered sample per clock. The multiplier output and the adder output are both registered. A plain loop would therefore need two cycles per sample. To avoid that, the recursion is unrolled one step: y[n] = b1²·y[n-2] + (x[n] + b1·x[n-1]).

The work is split into two stages. A feed-forward stage forms x[n] + b1·x[n-1]. A recursive stage multiplies the sample from two steps back by b1² and then adds the feed-forward term. Its loop is exactly two registers long. The coefficient is a signed Q1.(CW-1) value fixed when the block is built, and its magnitude must stay below 1. b1² is worked out at that time as well.

The result carries two guard bits above the input width. On overflow it clamps to the largest or smallest value it can hold instead of wrapping. Cycles with the input strobe low freeze every stage, so gaps in the input stream do not change the values produced.

Top module: `lookahead_iir`

## Requirements
- R1: With all state zero, the output sequence equals the direct recursion y[n] = b1·y[n-1] + x[n] wherever no rounding occurs. With b1 = 0.5 (code 16384) and an impulse of 1024, the outputs are 1024, 512, 256, … down to 1.
- R2: Define rnd(v, c) = floor((v·c + 2^(CW-2)) / 2^(CW-1)) and b2 = rnd(b1, b1). Each accepted sample produces exactly y[n] = sat(rnd(y[n-2], b2) + x[n] + rnd(x[n-1], b1)).
- R3: out_valid is in_valid delayed by exactly four clocks. out_sample takes its new value on the same edge that raises out_valid.
- R4: With in_valid held high, a new output is produced on every clock. No stall or bubble appears.
- R5: A cycle with in_valid low does not advance any stage. The value sequence depends only on the accepted samples. out_sample does not change while out_valid is low.
- R6: On overflow, the output clamps to 2^(DW+1)-1 or -2^(DW+1). Two non-negative terms never give a negative result, and two negative terms never give a non-negative one.
- R7: Synchronous reset clears every register to zero, so out_valid = 0 and out_sample = 0. The next accepted sample is treated as the first, with x[-1] = y[-1] = y[-2] = 0.
- R8: out_sample is DW+2 bits wide, in two's complement. For DW = 16 it can reach 131071 and -131072.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_sample as a new sample to accept |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Marks out_sample as a new filtered sample |
| out_sample | output | DW+2 | Signed filtered sample with two guard bits |

## Verification
The assertions take the input strobe to be a known 0 or 1 on every clock after reset. They also take the coefficient magnitude to be below one, so that b1² is positive and below one and a product never exceeds the operand it scales. The stimulus uses only coefficients of 0.9 and 0.5. It drives the strobe explicitly at every step, including during reset. Input values cover the full signed range: full-scale steps push the accumulator into clamping, and random bursts with gaps exercise the stall path.

// File: rtl/lookahead_iir.sv
module lookahead_iir #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int COEF = 29491
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW+1:0] out_sample
);

  localparam int AW   = DW + 2;
  localparam int F    = CW - 1;
  localparam int HALF = 1 << (F - 1);
  localparam int B2I  = (COEF * COEF + HALF) >>> F;
  localparam logic signed [CW-1:0] B1   = CW'(COEF);
  localparam logic signed [CW-1:0] B2   = CW'(B2I);
  localparam logic signed [AW-1:0] YMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {1'b1, {(AW-1){1'b0}}};

  logic                 v0, v1, v2, v3;
  logic signed [DW-1:0] xi, xc;
  logic signed [DW:0]   m1;
  logic signed [AW-1:0] s_acc, p_fb, y_acc;

  logic signed [DW+CW-1:0] ff_prod, ff_rnd;
  logic signed [AW+CW-1:0] fb_prod, fb_rnd;
  logic signed [AW:0]      sum;
  logic signed [AW-1:0]    s_nx, y_nx;

  assign ff_prod = xc * B1;
  assign ff_rnd  = ff_prod + $signed((DW+CW)'(HALF));
  assign fb_prod = y_acc * B2;
  assign fb_rnd  = fb_prod + $signed((AW+CW)'(HALF));
  assign s_nx    = {{2{xc[DW-1]}}, xc} + {m1[DW], m1};
  assign sum     = {p_fb[AW-1], p_fb} + {s_acc[AW-1], s_acc};
  assign y_nx    = (sum[AW] != sum[AW-1]) ? (sum[AW] ? YMIN : YMAX) : sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      {v0, v1, v2, v3} <= '0;
      xi    <= '0;
      xc    <= '0;
      m1    <= '0;
      s_acc <= '0;
      p_fb  <= '0;
      y_acc <= '0;
    end else begin
      v0 <= in_valid;
      v1 <= v0;
      v2 <= v1;
      v3 <= v2;
      if (in_valid) xi <= in_sample;
      if (v0) begin
        xc <= xi;
        m1 <= ff_rnd[F +: DW+1];
      end
      if (v1) s_acc <= s_nx;
      if (v2) begin
        p_fb  <= fb_rnd[F +: AW];
        y_acc <= y_nx;
      end
    end
  end

  assign out_valid  = v3;
  assign out_sample = y_acc;

  // R3
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample) || $past(rst));

  // R5
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v0 |=> $stable(xc) && $stable(m1));

  // R6
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    v2 && !p_fb[AW-1] && !s_acc[AW-1] |=> !y_acc[AW-1]);

  // R6
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    v2 && p_fb[AW-1] && s_acc[AW-1] |=> y_acc[AW-1]);

endmodule

// File: tb/lookahead_iir_bench.sv
module lookahead_iir_bench;

  localparam int F = 15;
  localparam longint YMAX = 131071;
  localparam longint YMIN = -131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic               ov0, ov1;
  logic signed [17:0] os0, os1;

  always #10 clk = ~clk;

  lookahead_iir u_lookahead_iir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov0), .out_sample(os0));

  lookahead_iir #(.COEF(16384)) u_lookahead_iir_half (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov1), .out_sample(os1));

  int n_tests = 0;
  int n_fail  = 0;
  string req = "R7";
  longint b1c[2] = '{29491, 16384};
  longint b2c[2];
  longint xp[2], y1[2], y2[2], lastout[2];
  longint expq0[$], expq1[$], halfseen[$];
  bit vq[$];

  function automatic longint rnd(longint v, longint c);
    return (v * c + (64'sd1 <<< (F - 1))) >>> F;
  endfunction

  function automatic longint sat(longint v);
    if (v > YMAX) return YMAX;
    if (v < YMIN) return YMIN;
    return v;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 2; i++) begin
      xp[i] = 0; y1[i] = 0; y2[i] = 0; lastout[i] = 0;
    end
    expq0.delete(); expq1.delete(); vq.delete();
  endtask

  task automatic model_accept(longint x);
    for (int i = 0; i < 2; i++) begin
      longint yn;
      yn = sat(rnd(y2[i], b2c[i]) + x + rnd(xp[i], b1c[i]));
      if (i == 0) expq0.push_back(yn); else expq1.push_back(yn);
      y2[i] = y1[i]; y1[i] = yn; xp[i] = x;
    end
  endtask

  task automatic chk_one(int i, logic v, logic signed [17:0] o, bit ev);
    longint got, exp;
    got = longint'(o);
    n_tests++;
    if (v !== ev) begin
      n_fail++;
      $display("FAIL R3 inst%0d out_valid got %0b exp %0b", i, v, ev);
    end
    if (v === 1'b1) begin
      if (i == 0 ? expq0.size() == 0 : expq1.size() == 0) begin
        n_fail++;
        $display("FAIL R5 inst%0d unexpected output got %0d exp none", i, got);
        return;
      end
      exp = (i == 0) ? expq0.pop_front() : expq1.pop_front();
      n_tests++;
      if (got != exp) begin
        n_fail++;
        $display("FAIL %s R2 inst%0d sample got %0d exp %0d", req, i, got, exp);
      end
      if (i == 1 && req == "R1") halfseen.push_back(got);
      lastout[i] = got;
    end else begin
      n_tests++;
      if (got != lastout[i]) begin
        n_fail++;
        $display("FAIL %s R5 inst%0d held sample got %0d exp %0d", req, i, got, lastout[i]);
      end
    end
  endtask

  task automatic step(bit r, bit v, longint x);
    bit ev;
    @(negedge clk);
    ev = (vq.size() >= 4) ? vq[vq.size() - 4] : 1'b0;
    chk_one(0, ov0, os0, ev);
    chk_one(1, ov1, os1, ev);
    rst = r;
    in_valid = v;
    in_sample = 16'(x);
    if (r) clear_model();
    else begin
      vq.push_back(v);
      if (v) model_accept(x);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired got running exp finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) b2c[i] = rnd(b1c[i], b1c[i]);
    clear_model();

    // R7: reset state
    req = "R7";
    for (int k = 0; k < 4; k++) step(1, 0, 0);

    // R1: impulse, exact for b1 = 0.5
    req = "R1";
    step(0, 1, 1024);
    for (int k = 0; k < 24; k++) step(0, 1, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0);
    n_tests++;
    if (halfseen.size() < 11) begin
      n_fail++;
      $display("FAIL R1 impulse outputs got %0d exp 11", halfseen.size());
    end else begin
      for (int k = 0; k < 11; k++) begin
        n_tests++;
        if (halfseen[k] != (64'sd1024 >>> k)) begin
          n_fail++;
          $display("FAIL R1 direct recursion n=%0d got %0d exp %0d",
                   k, halfseen[k], 64'sd1024 >>> k);
        end
      end
    end

    // R6 R8: full-scale steps drive the accumulator into clamping
    req = "R6 R8";
    for (int k = 0; k < 50; k++) step(0, 1, 32767);
    n_tests++;
    if (y1[0] != YMAX) begin
      n_fail++;
      $display("FAIL R6 model did not reach clamp got %0d exp %0d", y1[0], YMAX);
    end
    for (int k = 0; k < 60; k++) step(0, 1, -32768);

    // R5: random samples with gaps
    req = "R5";
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] r16;
      r16 = 16'($urandom);
      step(0, ($urandom % 10) < 7, longint'($signed(r16)));
    end

    // R4: random samples at full rate
    req = "R4";
    for (int k = 0; k < 1000; k++) begin
      logic [15:0] r16;
      r16 = 16'($urandom);
      step(0, 1, longint'($signed(r16)));
    end

    // R7: reset in mid-stream, then an impulse starts from zero state
    req = "R7";
    step(1, 1, 12345);
    step(1, 0, 0);
    step(0, 1, -5000);
    for (int k = 0; k < 12; k++) step(0, 1, 0);

    for (int k = 0; k < 8; k++) step(0, 0, 0);
    n_tests++;
    if (expq0.size() != 0 || expq1.size() != 0) begin
      n_fail++;
      $display("FAIL R4 outputs missing got %0d exp 0", expq0.size() + expq1.size());
    end
    summary();
    $finish;
  end

endmodule